// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This block holds the three sign flags of a 16-bit processor: negative, zero and positive. Whenever the control unit writes a result into a general register, it can also pulse a load strobe. The block then sorts the written value by its two's complement sign and stores exactly one of the three flags. Stores, branches and any other cycle without the strobe leave the flags as they are.

For a conditional branch, the decoder supplies the three-bit condition mask taken from the instruction, along with an evaluate strobe. The block returns a taken indication in the same cycle. The branch is taken when any flag chosen by the mask is currently set. If it is not taken, the program counter logic simply moves on to the next sequential instruction. Target arithmetic and program counter loading are done elsewhere.

Top module: `cc_branch_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) leaves the flags at zero-only, so flags_out reads 3'b010.
- R2: With flag_load high at a rising edge, a value whose most significant bit is 1 sets flags_out to 3'b100 (bit 2 is the negative flag). This covers 16'h8000 and 16'hFFFF.
- R3: With flag_load high at a rising edge, the value 0 sets flags_out to 3'b010 (bit 1 is the zero flag).
- R4: With flag_load high at a rising edge, a nonzero value whose most significant bit is 0 sets flags_out to 3'b001 (bit 0 is the positive flag). This covers 16'h0001 and 16'h7FFF.
- R5: While flag_load is low, a rising edge leaves flags_out unchanged, whatever wr_value holds.
- R6: Exactly one bit of flags_out is set in every cycle after reset.
- R7: While br_eval is high, br_taken equals the OR of (br_mask AND flags_out) in the same cycle, with no clock delay. br_mask bit 2 selects negative, bit 1 selects zero and bit 0 selects positive.
- R8: A mask of 3'b000 never gives a taken branch. A mask of 3'b111 with br_eval high always gives a taken branch.
- R9: While br_eval is low, br_taken is 0 for every mask and flag state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_value | input | 16 | Value being written to a general register |
| flag_load | input | 1 | Capture the sign of wr_value into the flags |
| br_mask | input | 3 | Branch condition mask {n, z, p} |
| br_eval | input | 1 | A branch is being resolved this cycle |
| br_taken | output | 1 | Branch taken decision |
| flags_out | output | 3 | Current flags {N, Z, P} |

## Verification
Directed values sit on the sign boundaries: 0, 1, 16'h7FFF, 16'h8000 and 16'hFFFF. They show whether the classifier confuses zero with positive and whether it reads the sign from the correct bit. Every one of the eight masks is tried against each of the three flag states, which separates an OR over the selected flags from an AND or from a wrong bit order. Random values, load strobes and evaluate strobes, mixed together with a fixed seed, then test holding when the strobe is low and gating by br_eval against a model of the flags kept in the bench.

// File: rtl/cc_pkg.sv
// Shared types for the condition flag unit.
// Assumes flags are packed {neg, zer, pos}, with neg as the most significant bit.
package cc_pkg;
    localparam int NUM_FLAGS = 3;

    typedef struct packed {
        logic neg;
        logic zer;
        logic pos;
    } cc_flags_t;

    localparam cc_flags_t CC_RESET = '{neg: 1'b0, zer: 1'b1, pos: 1'b0};
endpackage

// File: rtl/cc_sign_classify.sv
// Sorts a two's complement value into negative, zero or strictly positive.
// Assumes a WIDTH-bit signed value; the result always has exactly one bit set.
module cc_sign_classify
    import cc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] value,
    output cc_flags_t        cls
);
    localparam int SIGN_BIT = WIDTH - 1;

    logic is_zero;

    // Zero detect over the whole word.
    always_comb is_zero = (value == '0);

    // Pick the single flag that matches the value.
    always_comb begin
        cls.neg = value[SIGN_BIT];
        cls.zer = is_zero;
        cls.pos = !value[SIGN_BIT] && !is_zero;
    end
endmodule

// File: rtl/cc_flag_reg.sv
// Holds the flags and loads them only when the strobe is high.
// Assumes the synchronous active-low reset sets the zero flag alone.
module cc_flag_reg
    import cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  cc_flags_t next_flags,
    output cc_flags_t flags
);
    // Flag storage with reset and load-enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= CC_RESET;
        else if (load)
            flags <= next_flags;
    end
endmodule

// File: rtl/cc_branch_eval.sv
// Combinational branch decision: OR over the flags selected by the mask, gated by the strobe.
// Assumes mask and flag vectors share the same bit order.
module cc_branch_eval #(
    parameter int NUM_FLAGS = 3
) (
    input  logic [NUM_FLAGS-1:0] mask,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 eval,
    output logic                 taken
);
    logic [NUM_FLAGS-1:0] hit;

    // One select term per flag.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sel
        assign hit[i] = mask[i] & flags[i];
    end

    // Any selected flag set, qualified by the strobe.
    always_comb taken = eval && (|hit);
endmodule

// File: rtl/cc_branch_unit.sv
// Top of the condition flag and branch decision unit.
// Assumes flag_load is high only for register-writing instructions; br_taken is combinational.
module cc_branch_unit
    import cc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_value,
    input  logic             flag_load,
    input  logic [2:0]       br_mask,
    input  logic             br_eval,
    output logic             br_taken,
    output logic [2:0]       flags_out
);
    cc_flags_t cls;
    cc_flags_t cur;

    cc_sign_classify #(.WIDTH(WIDTH)) u_cls (
        .value (wr_value),
        .cls   (cls)
    );

    cc_flag_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (flag_load),
        .next_flags (cls),
        .flags      (cur)
    );

    cc_branch_eval #(.NUM_FLAGS(NUM_FLAGS)) u_br (
        .mask  (br_mask),
        .flags (cur),
        .eval  (br_eval),
        .taken (br_taken)
    );

    // Expose the stored flags as a plain vector.
    always_comb flags_out = cur;
endmodule

// File: rtl/cc_branch_unit_chk.sv
// Property checker for cc_branch_unit, attached with bind.
module cc_branch_unit_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] wr_value,
    input logic             flag_load,
    input logic [2:0]       br_mask,
    input logic             br_eval,
    input logic             br_taken,
    input logic [2:0]       flags_out
);
    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> flags_out == 3'b010);
    // R2
    neg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && wr_value[WIDTH-1]) |=> flags_out == 3'b100);
    // R3
    zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && wr_value == '0) |=> flags_out == 3'b010);
    // R4
    pos_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && !wr_value[WIDTH-1] && wr_value != '0) |=> flags_out == 3'b001);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_load |=> $stable(flags_out));
    // R6
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags_out) == 1);
    // R8
    never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_mask == 3'b000 |-> !br_taken);
    // R8
    always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_eval && br_mask == 3'b111) |-> br_taken);
    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_eval |-> !br_taken);
endmodule

bind cc_branch_unit cc_branch_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_value  (wr_value),
    .flag_load (flag_load),
    .br_mask   (br_mask),
    .br_eval   (br_eval),
    .br_taken  (br_taken),
    .flags_out (flags_out)
);

// File: tb/cc_branch_unit_test.sv
module cc_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] wr_value = '0;
    logic        flag_load = 1'b0;
    logic [2:0]  br_mask = '0;
    logic        br_eval = 1'b0;
    logic        br_taken;
    logic [2:0]  flags_out;

    int tests = 0;
    int fails = 0;
    logic [2:0] model = 3'b010;

    always #2 clk = ~clk;

    cc_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_value(wr_value), .flag_load(flag_load),
        .br_mask(br_mask), .br_eval(br_eval), .br_taken(br_taken), .flags_out(flags_out)
    );

    function automatic logic [2:0] sign_of(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic taken_of(input logic [2:0] m, input logic [2:0] f, input logic e);
        return e && ((m & f) != 3'b000);
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the combinational decision, then clock.
    task automatic step(input logic [15:0] v, input logic ld, input logic [2:0] m,
                        input logic e, input string req);
        wr_value = v; flag_load = ld; br_mask = m; br_eval = e;
        #1;
        check({req, " taken"}, {2'b00, br_taken}, {2'b00, taken_of(m, model, e)});
        check("R6 flags", flags_out, model);
        @(posedge clk);
        if (ld) model = sign_of(v);
        @(negedge clk);
        check({req, " flags"}, flags_out, model);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", flags_out, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", flags_out, 3'b010);
        // Directed sign boundaries
        step(16'h8000, 1'b1, 3'b000, 1'b0, "R2");
        step(16'hFFFF, 1'b1, 3'b100, 1'b1, "R2");
        step(16'h0000, 1'b1, 3'b010, 1'b1, "R3");
        step(16'h0001, 1'b1, 3'b001, 1'b1, "R4");
        step(16'h7FFF, 1'b1, 3'b110, 1'b1, "R4");
        // R5 value ignored without the strobe
        step(16'h8000, 1'b0, 3'b001, 1'b1, "R5");
        step(16'h0000, 1'b0, 3'b001, 1'b1, "R5");
        // R7 R8 R9 every mask against every flag state
        for (int s = 0; s < 3; s++) begin
            logic [15:0] v;
            v = (s == 0) ? 16'hC000 : (s == 1) ? 16'h0000 : 16'h0042;
            step(v, 1'b1, 3'b000, 1'b0, "R7");
            for (int m = 0; m < 8; m++) begin
                step(16'h1234, 1'b0, 3'(m), 1'b1, m == 0 || m == 7 ? "R8" : "R7");
                step(16'h1234, 1'b0, 3'(m), 1'b0, "R9");
            end
        end
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] v;
            int k;
            k = $urandom_range(0, 5);
            v = (k == 0) ? 16'h0000 : (k == 1) ? 16'h8000 : (k == 2) ? 16'h7FFF : 16'($urandom);
            step(v, 1'($urandom), 3'($urandom), 1'($urandom), "R7");
        end
        // R1 reset again from a non-zero state
        step(16'h0005, 1'b1, 3'b000, 1'b0, "R4");
        rst_n = 1'b0;
        @(negedge clk);
        model = 3'b010;
        check("R1", flags_out, 3'b010);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule